// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible register set of one descriptor-driven DMA channel. It sits behind a simple 32-bit register bus with a one-cycle write strobe and a read strobe whose data comes back on the following clock. It holds the channel's control and status word, the address of the descriptor to run, a free read/write debug word and read-only copies of the descriptor the transfer engine has currently loaded.

The status word mixes several kinds of bits. The completion and interrupt flags are cleared by writing a 1 to them. A masked group (active, plus bits 16 to 23, 28 and 29) is simply replaced by the written value. A reset command clears the channel. An abort command is accepted but has no effect. Hardware-owned bits are driven from the engine side: flow-control hold, a sticky error and the completion bookkeeping.

When a write moves the active bit from 0 to 1, the block sends a start pulse to the engine. When the engine reports completion, the block updates the status word and, if the loaded descriptor asks for it, raises the channel interrupt until software clears it.

Top module: `dmach_regfile`

## Requirements
- R1: After reset, every defined register reads 0, and irq, eng_start and int_ack are low.
- R2: A status write with bit 31 set clears the whole status word and the descriptor address register (offset 0x04). Bit 31 never reads back as 1, and a raised irq drops on the clock after that write.
- R3: In a status write (offset 0x00), a 1 in bit 1 clears the end flag and a 1 in bit 2 clears the interrupt flag. Clearing the interrupt flag drops irq and pulses int_ack for one cycle on the clock after the write. A 0 in either bit leaves that flag unchanged.
- R4: After those clears, the status bits under mask 0x30FF0001 take the written value. Writes to any other status bit (for example paused at bit 4, held at bit 5, error at bit 8) have no effect.
- R5: A status write that changes active (bit 0) from 0 to 1 makes eng_start high for exactly the cycle after the write and clears paused (bit 4). A write of 1 while active is already 1 produces no start.
- R6: Writing the abort bit (bit 30) has no effect: bit 30 reads 0, no start is issued and the other bits follow R3 and R4 alone.
- R7: The descriptor address (offset 0x04) and the debug word (offset 0x20) are read/write and return the last value written.
- R8: On eng_load, the block captures the descriptor words (info, source, destination, length, stride, next) and shows them read-only at offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C. Bus writes to these offsets are ignored.
- R9: On eng_done, the block clears active, sets end (bit 1) and sets paused (bit 4). If bit 0 of the loaded info word is 1, it also sets the interrupt flag (bit 2), and irq stays high until that flag is cleared.
- R10: An eng_err pulse sets the error bit (bit 8), which stays set until a channel reset write. Bit 5 follows the eng_held input one clock later.
- R11: A read of an undefined offset (misaligned, 0x24 or above) returns 0. A write to such an offset changes no register.
- R12: Read data for a bus_rd strobe appears on bus_rdata on the clock after the strobe and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after bus_rd |
| eng_start | output | 1 | One-cycle start request to the transfer engine |
| eng_load | input | 1 | Engine has loaded a new descriptor |
| eng_desc | input | DESC_WORDS*DATA_W | Loaded descriptor words, word 0 (info) in the low bits |
| eng_done | input | 1 | Engine has finished the current descriptor |
| eng_held | input | 1 | Engine is held by flow control |
| eng_err | input | 1 | Engine error pulse |
| irq | output | 1 | Channel interrupt, level |
| int_ack | output | 1 | One-cycle pulse to clear this channel's bit in a global interrupt status |

## Verification
The properties assume that the engine strobes follow the bus rules of the channel. eng_done and eng_load come as single-cycle pulses. eng_done does not share a cycle with a status write that targets the bits it updates, because an engine event in the same cycle as a write takes precedence for end, active, paused and interrupt. The stimulus drives every strobe at the falling edge for one cycle only, lets each engine event settle before the next register write, and raises eng_done only after a start, so the ordering between bus clears and engine sets never depends on this precedence.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
   localparam int CS_ACTIVE = 0;
   localparam int CS_END    = 1;
   localparam int CS_INT    = 2;
   localparam int CS_PAUSED = 4;
   localparam int CS_HELD   = 5;
   localparam int CS_ERR    = 8;
   localparam int CS_ABORT  = 30;
   localparam int CS_RESET  = 31;
   localparam logic [31:0] CS_RW_MASK = 32'h30FF_0001;
   localparam int INFO_IRQ_EN = 0;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CS,
      SEL_CBADDR,
      SEL_SHADOW,
      SEL_DEBUG
   } dmach_sel_e;
endpackage

// File: rtl/dmach_addr_dec.sv
module dmach_addr_dec #(
   parameter int ADDR_W     = 8,
   parameter int DESC_WORDS = 6,
   parameter int IDX_W      = 3
) (
   input  logic [ADDR_W-1:0]     addr,
   output dmach_pkg::dmach_sel_e sel,
   output logic [IDX_W-1:0]      idx
);
   import dmach_pkg::*;
   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] W_CS     = WORD_W'(0);
   localparam logic [WORD_W-1:0] W_CBADDR = WORD_W'(1);
   localparam logic [WORD_W-1:0] W_SH0    = WORD_W'(2);
   localparam logic [WORD_W-1:0] W_DEBUG  = WORD_W'(2 + DESC_WORDS);

   logic [WORD_W-1:0] word;
   logic              aligned;
   logic [WORD_W-1:0] rel;

   assign word    = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign rel     = word - W_SH0;

   always_comb begin
      sel = SEL_NONE;
      idx = IDX_W'(rel);
      if (aligned) begin
         if (word == W_CS)
            sel = SEL_CS;
         else if (word == W_CBADDR)
            sel = SEL_CBADDR;
         else if (word >= W_SH0 && word < W_DEBUG)
            sel = SEL_SHADOW;
         else if (word == W_DEBUG)
            sel = SEL_DEBUG;
      end
   end
endmodule

// File: rtl/dmach_status.sv
module dmach_status #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cs,
   input  logic [DATA_W-1:0] wdata,
   input  logic              eng_done,
   input  logic              eng_held,
   input  logic              eng_err,
   input  logic              irq_en,
   output logic [DATA_W-1:0] cs_q,
   output logic              start_q,
   output logic              int_ack_q
);
   import dmach_pkg::*;
   localparam logic [DATA_W-1:0] RW_MASK = DATA_W'(CS_RW_MASK);

   logic [DATA_W-1:0] cs_nxt;
   logic              start_c;
   logic              ack_c;

   assign start_c = wr_cs & wdata[CS_ACTIVE] & ~cs_q[CS_ACTIVE];
   assign ack_c   = wr_cs & (wdata[CS_INT] | wdata[CS_RESET]);

   always_comb begin
      cs_nxt = cs_q;
      if (wr_cs) begin
         if (wdata[CS_RESET])
            cs_nxt = '0;
         if (wdata[CS_END])
            cs_nxt[CS_END] = 1'b0;
         if (wdata[CS_INT])
            cs_nxt[CS_INT] = 1'b0;
         cs_nxt = (cs_nxt & ~RW_MASK) | (wdata & RW_MASK);
      end
      if (start_c)
         cs_nxt[CS_PAUSED] = 1'b0;
      cs_nxt[CS_HELD] = eng_held;
      if (eng_err)
         cs_nxt[CS_ERR] = 1'b1;
      if (eng_done) begin
         cs_nxt[CS_ACTIVE] = 1'b0;
         cs_nxt[CS_END]    = 1'b1;
         cs_nxt[CS_PAUSED] = 1'b1;
         if (irq_en)
            cs_nxt[CS_INT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= '0;
         start_q   <= 1'b0;
         int_ack_q <= 1'b0;
      end else begin
         cs_q      <= cs_nxt;
         start_q   <= start_c;
         int_ack_q <= ack_c;
      end
   end
endmodule

// File: rtl/dmach_desc_shadow.sv
module dmach_desc_shadow #(
   parameter int DATA_W     = 32,
   parameter int DESC_WORDS = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [DESC_WORDS*DATA_W-1:0] desc_in,
   output logic [DESC_WORDS*DATA_W-1:0] desc_q
);
   for (genvar k = 0; k < DESC_WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            desc_q[k*DATA_W +: DATA_W] <= '0;
         else if (load)
            desc_q[k*DATA_W +: DATA_W] <= desc_in[k*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/dmach_rd_port.sv
module dmach_rd_port #(
   parameter int DATA_W     = 32,
   parameter int DESC_WORDS = 6,
   parameter int IDX_W      = 3,
   parameter bit IDLE_ZERO  = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd,
   input  dmach_pkg::dmach_sel_e        sel,
   input  logic [IDX_W-1:0]             idx,
   input  logic [DATA_W-1:0]            cs,
   input  logic [DATA_W-1:0]            cbaddr,
   input  logic [DATA_W-1:0]            dbg,
   input  logic [DESC_WORDS*DATA_W-1:0] shadow,
   output logic [DATA_W-1:0]            rdata
);
   import dmach_pkg::*;
   logic [DATA_W-1:0] mux;

   always_comb begin
      unique case (sel)
         SEL_CS:     mux = cs;
         SEL_CBADDR: mux = cbaddr;
         SEL_SHADOW: mux = shadow[idx*DATA_W +: DATA_W];
         SEL_DEBUG:  mux = dbg;
         default:    mux = '0;
      endcase
   end

   if (IDLE_ZERO) begin : g_idle_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata <= '0;
         else
            rdata <= rd ? mux : '0;
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata <= '0;
         else if (rd)
            rdata <= mux;
      end
   end
endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int DESC_WORDS = 6,
   parameter bit IDLE_ZERO  = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   output logic                         eng_start,
   input  logic                         eng_load,
   input  logic [DESC_WORDS*DATA_W-1:0] eng_desc,
   input  logic                         eng_done,
   input  logic                         eng_held,
   input  logic                         eng_err,
   output logic                         irq,
   output logic                         int_ack
);
   import dmach_pkg::*;
   localparam int IDX_W    = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
   localparam int SPAN_B   = 4 * (DESC_WORDS + 3);
   localparam int MIN_A_W  = $clog2(SPAN_B);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("dmach_regfile: DATA_W must be 32");
   end
   if (DESC_WORDS < 1 || DESC_WORDS > 14) begin : g_bad_desc
      $error("dmach_regfile: DESC_WORDS out of range");
   end
   if (ADDR_W < MIN_A_W || ADDR_W < 3) begin : g_bad_addr_w
      $error("dmach_regfile: ADDR_W too small for register span");
   end

   dmach_sel_e        sel;
   logic [IDX_W-1:0]  idx;
   logic              wr_cs;
   logic              wr_cbaddr;
   logic              wr_debug;
   logic [DATA_W-1:0] cs_q;
   logic [DATA_W-1:0] cbaddr_q;
   logic [DATA_W-1:0] debug_q;
   logic [DESC_WORDS*DATA_W-1:0] shadow_q;

   dmach_addr_dec #(
      .ADDR_W     (ADDR_W),
      .DESC_WORDS (DESC_WORDS),
      .IDX_W      (IDX_W)
   ) u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .idx  (idx)
   );

   assign wr_cs     = bus_wr && (sel == SEL_CS);
   assign wr_cbaddr = bus_wr && (sel == SEL_CBADDR);
   assign wr_debug  = bus_wr && (sel == SEL_DEBUG);

   dmach_status #(
      .DATA_W (DATA_W)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cs     (wr_cs),
      .wdata     (bus_wdata),
      .eng_done  (eng_done),
      .eng_held  (eng_held),
      .eng_err   (eng_err),
      .irq_en    (shadow_q[INFO_IRQ_EN]),
      .cs_q      (cs_q),
      .start_q   (eng_start),
      .int_ack_q (int_ack)
   );

   dmach_desc_shadow #(
      .DATA_W     (DATA_W),
      .DESC_WORDS (DESC_WORDS)
   ) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (eng_load),
      .desc_in (eng_desc),
      .desc_q  (shadow_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cbaddr_q <= '0;
         debug_q  <= '0;
      end else begin
         if (wr_cs && bus_wdata[CS_RESET])
            cbaddr_q <= '0;
         else if (wr_cbaddr)
            cbaddr_q <= bus_wdata;
         if (wr_debug)
            debug_q <= bus_wdata;
      end
   end

   dmach_rd_port #(
      .DATA_W     (DATA_W),
      .DESC_WORDS (DESC_WORDS),
      .IDX_W      (IDX_W),
      .IDLE_ZERO  (IDLE_ZERO)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (bus_rd),
      .sel    (sel),
      .idx    (idx),
      .cs     (cs_q),
      .cbaddr (cbaddr_q),
      .dbg    (debug_q),
      .shadow (shadow_q),
      .rdata  (bus_rdata)
   );

   assign irq = cs_q[CS_INT];
endmodule

// File: rtl/dmach_regfile_chk.sv
module dmach_regfile_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_cs,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] cs_q,
   input logic              irq,
   input logic              eng_start,
   input logic              eng_done,
   input logic              int_ack
);
   // R5: a start pulse only follows a write that raised active
   a_r5_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> $past(wr_cs && bus_wdata[0] && !cs_q[0]));

   // R5: rewriting active while already active never starts again
   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_cs && cs_q[0]) |-> !eng_start);

   // R3: irq falls only after an interrupt clear or reset write
   a_r3_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_cs && (bus_wdata[2] || bus_wdata[31])));

   // R3: the global clear pulse has a matching write behind it
   a_r3_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |-> $past(wr_cs && (bus_wdata[2] || bus_wdata[31])));

   // R4: masked upper field follows the last status write
   a_r4_rw_field: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_cs) |-> ((cs_q & 32'h30FF_0000) == ($past(bus_wdata) & 32'h30FF_0000)));

   // R9: completion bookkeeping
   a_r9_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eng_done) |-> (cs_q[1] && !cs_q[0] && cs_q[4]));

   // R2: reset command never stored
   a_r2_reset_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_q[31]);

   // R6: abort command never stored
   a_r6_abort_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_q[30]);
endmodule

bind dmach_regfile dmach_regfile_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_cs     (wr_cs),
   .bus_wdata (bus_wdata),
   .cs_q      (cs_q),
   .irq       (irq),
   .eng_start (eng_start),
   .eng_done  (eng_done),
   .int_ack   (int_ack)
);

// File: tb/dmach_regfile_test.sv
module dmach_regfile_test;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int NW     = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              eng_start;
   logic              eng_load = 1'b0;
   logic [NW*DATA_W-1:0] eng_desc = '0;
   logic              eng_done = 1'b0;
   logic              eng_held = 1'b0;
   logic              eng_err = 1'b0;
   logic              irq;
   logic              int_ack;

   int checks = 0;
   int failures = 0;
   logic [31:0] expq[$];
   string       tagq[$];

   always #4 clk = ~clk;

   dmach_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DESC_WORDS(NW), .IDLE_ZERO(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_start(eng_start), .eng_load(eng_load), .eng_desc(eng_desc),
      .eng_done(eng_done), .eng_held(eng_held), .eng_err(eng_err),
      .irq(irq), .int_ack(int_ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: read data lands on the clock after the strobe (R12)
   always @(posedge clk) begin
      #2;
      if (rst_n && bus_rd) begin
         if (expq.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R12 unexpected read actual=%h expected=none", bus_rdata);
         end else begin
            chk(tagq.pop_front(), bus_rdata, expq.pop_front());
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      expq.push_back(exp);
      tagq.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic load(input logic [31:0] info, input logic [31:0] base);
      @(negedge clk);
      eng_load = 1'b1;
      eng_desc = {base + 32'h50, base + 32'h40, base + 32'h30,
                  base + 32'h20, base + 32'h10, info};
      @(negedge clk);
      eng_load = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 eng_start", {31'b0, eng_start}, 32'h0);
      chk("R1 int_ack", {31'b0, int_ack}, 32'h0);
      for (int k = 0; k < 9; k++)
         rd(8'(4 * k), 32'h0, "R1 reg after reset");

      // R7 read/write words
      wr(8'h04, 32'h1234_5670);
      wr(8'h20, 32'hDEAD_BEEF);
      rd(8'h04, 32'h1234_5670, "R7 descriptor address");
      rd(8'h20, 32'hDEAD_BEEF, "R7 debug word");

      // R8 shadows
      load(32'h0000_0001, 32'h1000_0000);
      rd(8'h08, 32'h0000_0001, "R8 info");
      for (int k = 1; k < 6; k++)
         rd(8'(8 + 4 * k), 32'h1000_0000 + 32'(16 * k), "R8 shadow word");
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h08, 32'h0000_0001, "R8 write to info ignored");
      rd(8'h14, 32'h1000_0030, "R8 write to length ignored");

      // R5 start on rising active
      wr(8'h00, 32'h0000_0001);
      chk("R5 start pulse", {31'b0, eng_start}, 32'h1);
      @(negedge clk);
      chk("R5 start single cycle", {31'b0, eng_start}, 32'h0);
      rd(8'h00, 32'h0000_0001, "R4 active stored");
      wr(8'h00, 32'h0000_0001);
      chk("R5 no restart while active", {31'b0, eng_start}, 32'h0);

      // R9 completion with interrupt enable
      done_pulse();
      chk("R9 irq raised", {31'b0, irq}, 32'h1);
      rd(8'h00, 32'h0000_0016, "R9 done flags");
      repeat (3) @(negedge clk);
      chk("R9 irq held", {31'b0, irq}, 32'h1);

      // R3 write-one-to-clear
      wr(8'h00, 32'h0000_0004);
      chk("R3 irq cleared", {31'b0, irq}, 32'h0);
      chk("R3 int_ack pulse", {31'b0, int_ack}, 32'h1);
      @(negedge clk);
      chk("R3 int_ack single", {31'b0, int_ack}, 32'h0);
      rd(8'h00, 32'h0000_0012, "R3 end kept int cleared");
      wr(8'h00, 32'h0000_0002);
      rd(8'h00, 32'h0000_0010, "R3 end cleared");

      // R4 masked replace, R5 paused clear on start
      wr(8'h00, 32'h30FF_0131);
      chk("R5 start from field write", {31'b0, eng_start}, 32'h1);
      rd(8'h00, 32'h30FF_0001, "R4 masked field and R5 paused cleared");

      // R6 abort ignored
      wr(8'h00, 32'h70FF_0001);
      chk("R6 abort no start", {31'b0, eng_start}, 32'h0);
      rd(8'h00, 32'h30FF_0001, "R6 abort not stored");

      // R10 error and held
      @(negedge clk);
      eng_err = 1'b1; eng_held = 1'b1;
      @(negedge clk);
      eng_err = 1'b0;
      rd(8'h00, 32'h30FF_0121, "R10 error and held");
      @(negedge clk);
      eng_held = 1'b0;
      @(negedge clk);
      rd(8'h00, 32'h30FF_0101, "R10 held follows error sticky");

      // R9 completion without interrupt enable
      load(32'h0000_0000, 32'h2000_0000);
      done_pulse();
      chk("R9 no irq when disabled", {31'b0, irq}, 32'h0);
      rd(8'h00, 32'h30FF_0112, "R9 done no int");

      // R2 channel reset
      load(32'h0000_0001, 32'h3000_0000);
      done_pulse();
      chk("R9 irq with enable", {31'b0, irq}, 32'h1);
      wr(8'h04, 32'h000A_BCD0);
      wr(8'h00, 32'h8000_0000);
      chk("R2 irq dropped by reset", {31'b0, irq}, 32'h0);
      rd(8'h00, 32'h0000_0000, "R2 status cleared");
      rd(8'h04, 32'h0000_0000, "R2 descriptor address cleared");

      // R11 undefined offsets
      wr(8'h04, 32'h0000_0040);
      wr(8'h06, 32'hFFFF_FFFF);
      wr(8'h24, 32'h5555_5555);
      rd(8'h04, 32'h0000_0040, "R11 misaligned write ignored");
      rd(8'h20, 32'hDEAD_BEEF, "R11 undefined write ignored");
      rd(8'h24, 32'h0000_0000, "R11 read 0x24");
      rd(8'h80, 32'h0000_0000, "R11 read 0x80");
      rd(8'h02, 32'h0000_0000, "R11 misaligned read");

      // R12 hold between reads
      rd(8'h20, 32'hDEAD_BEEF, "R12 read debug");
      repeat (3) @(negedge clk);
      chk("R12 data held", bus_rdata, 32'hDEAD_BEEF);

      repeat (3) @(negedge clk);
      chk("R12 scoreboard drained", 32'(expq.size()), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule